// File: doc/BRIEF.md
# Quadword Byte-Lane and Shift Execution Unit

This unit executes one operate group of integer instructions that work on 64-bit little-endian quadwords at byte granularity: clearing selected bytes, masking out a byte field, pulling a field down to the bottom of the word, placing a byte into a lane, and logical shifts left or right. An issue stage presents operand A, operand B (either a register value or an 8-bit literal that is zero-extended), a 7-bit function code and a destination index with a one-cycle valid strobe.

Every operation is built from the same two pieces: a barrel shifter and one byte-lane clearing network driven by an 8-bit keep mask. The low three bits of B give a byte offset; the mask generator turns the function code and that offset into the keep mask, and the shifter moves the data by the offset in bytes or by B[5:0] in bits. The result, a write-enable and an illegal-function flag appear registered on the clock after the strobe.

Top module: `bytezap_unit`

## Requirements
- R1: While reset is high (synchronous), and on the first edge after it, the result is all zeros and the write-enable and illegal flag are low.
- R2: Function 0x30 clears each byte lane i (lane 0 is bits [7:0], lane 7 bits [63:56]) of A for which B[i] is 1; function 0x31 clears each lane for which B[i] is 0.
- R3: Functions 0x02, 0x12, 0x22, 0x32 clear a field of 1, 2, 4 or 8 bytes of A starting at lane B[2:0]; lanes of the field beyond lane 7 are dropped, so other lanes keep A.
- R4: Functions 0x06, 0x16, 0x26, 0x36 shift A right by 8*B[2:0] bits, then keep only the low 1, 2, 4 or 8 bytes and clear the rest.
- R5: Function 0x0B shifts A left by 8*B[2:0] bits and keeps only lane B[2:0]; all other lanes are zero.
- R6: Function 0x34 shifts A right logically, and 0x39 shifts A left, by B[5:0] bits; higher bits of B have no effect.
- R7: When the literal select is high, B is the 8-bit literal zero-extended to 64 bits and the register operand is ignored.
- R8: A destination index of 31 keeps the write-enable low while the result is still produced.
- R9: Any other function code raises the illegal flag for one cycle, keeps the write-enable low and loads a zero result.
- R10: Outputs update one clock after a valid strobe; in a cycle without a strobe, the write-enable and illegal flag go low on the next edge and the result holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| opa | input | 64 | Operand A |
| opb | input | 64 | Register form of operand B |
| lit_sel | input | 1 | Take B from the literal instead of opb |
| lit | input | 8 | Literal form of operand B |
| func | input | 7 | Function code within the group |
| dest | input | 5 | Destination register index |
| res | output | 64 | Registered result |
| wr_en | output | 1 | Registered write-enable |
| illegal | output | 1 | Registered illegal-function flag |

## Verification
The assertions assume that reset is held for at least one edge before the first strobe and that inputs are stable around the rising edge; stable holding of the result between strobes is checked only because the unit does not load on idle cycles. The stimulus drives inputs just after the falling edge, inserts idle cycles between bursts, and sweeps every byte offset for each mask, extract and insert function, both operand sources, destination 31 and a set of unassigned function codes, so every assertion antecedent is reached with well-defined operands.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    localparam int FN_W = 7;

    typedef enum logic [2:0] {
        K_ZAP,
        K_ZAPNOT,
        K_MSK,
        K_EXT,
        K_INS,
        K_SRL,
        K_SLL,
        K_NONE
    } kind_e;

    // field width code: 0 -> 1 byte, 1 -> 2, 2 -> 4, 3 -> 8
    typedef logic [1:0] wcode_t;

    localparam logic [FN_W-1:0] FN_MSKB  = 7'h02;
    localparam logic [FN_W-1:0] FN_EXTB  = 7'h06;
    localparam logic [FN_W-1:0] FN_INSB  = 7'h0B;
    localparam logic [FN_W-1:0] FN_MSKW  = 7'h12;
    localparam logic [FN_W-1:0] FN_EXTW  = 7'h16;
    localparam logic [FN_W-1:0] FN_MSKL  = 7'h22;
    localparam logic [FN_W-1:0] FN_EXTL  = 7'h26;
    localparam logic [FN_W-1:0] FN_ZAP   = 7'h30;
    localparam logic [FN_W-1:0] FN_ZAPN  = 7'h31;
    localparam logic [FN_W-1:0] FN_MSKQ  = 7'h32;
    localparam logic [FN_W-1:0] FN_SRL   = 7'h34;
    localparam logic [FN_W-1:0] FN_EXTQ  = 7'h36;
    localparam logic [FN_W-1:0] FN_SLL   = 7'h39;

endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
    import bsu_pkg::*;
(
    input  logic [FN_W-1:0] func,
    output kind_e           kind,
    output wcode_t          wcode,
    output logic            legal
);
    always_comb begin
        kind  = K_NONE;
        wcode = 2'd0;
        legal = 1'b1;
        unique case (func)
            FN_ZAP:  kind = K_ZAP;
            FN_ZAPN: kind = K_ZAPNOT;
            FN_MSKB: begin kind = K_MSK; wcode = 2'd0; end
            FN_MSKW: begin kind = K_MSK; wcode = 2'd1; end
            FN_MSKL: begin kind = K_MSK; wcode = 2'd2; end
            FN_MSKQ: begin kind = K_MSK; wcode = 2'd3; end
            FN_EXTB: begin kind = K_EXT; wcode = 2'd0; end
            FN_EXTW: begin kind = K_EXT; wcode = 2'd1; end
            FN_EXTL: begin kind = K_EXT; wcode = 2'd2; end
            FN_EXTQ: begin kind = K_EXT; wcode = 2'd3; end
            FN_INSB: begin kind = K_INS; wcode = 2'd0; end
            FN_SRL:  kind = K_SRL;
            FN_SLL:  kind = K_SLL;
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/bsu_lanemask.sv
module bsu_lanemask
    import bsu_pkg::*;
#(
    parameter int LANES = 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  kind_e              kind,
    input  wcode_t             wcode,
    input  logic [LANES-1:0]   bsel,
    output logic [LANES-1:0]   keep
);
    logic [OFF_W-1:0] off;
    logic [LANES-1:0] field;
    logic [LANES-1:0] field_at_off;
    logic [LANES-1:0] one_lane;

    assign off = bsel[OFF_W-1:0];

    // lane i belongs to the field when i < 2**wcode
    for (genvar i = 0; i < LANES; i++) begin : g_field
        assign field[i] = (i < (1 << wcode));
    end

    // shifting within LANES bits drops lanes pushed past the top
    assign field_at_off = field << off;
    assign one_lane     = {{(LANES-1){1'b0}}, 1'b1} << off;

    always_comb begin
        unique case (kind)
            K_ZAP:    keep = ~bsel;
            K_ZAPNOT: keep = bsel;
            K_MSK:    keep = ~field_at_off;
            K_EXT:    keep = field;
            K_INS:    keep = one_lane;
            K_SRL,
            K_SLL:    keep = '1;
            default:  keep = '0;
        endcase
    end
endmodule

// File: rtl/bsu_shifter.sv
module bsu_shifter #(
    parameter int DATA_W = 64,
    localparam int SH_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    input  logic              left,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stage [SH_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        always_comb begin
            if (!amt[k])
                stage[k+1] = stage[k];
            else if (left)
                stage[k+1] = stage[k] << (1 << k);
            else
                stage[k+1] = stage[k] >> (1 << k);
        end
    end

    assign dout = stage[SH_W];
endmodule

// File: rtl/bsu_zap.sv
module bsu_zap #(
    parameter int LANES = 8,
    localparam int DATA_W = LANES * 8
) (
    input  logic [DATA_W-1:0] din,
    input  logic [LANES-1:0]  keep,
    output logic [DATA_W-1:0] dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[8*i +: 8] = keep[i] ? din[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/bytezap_unit.sv
module bytezap_unit
    import bsu_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int LIT_W    = 8,
    parameter int REG_W    = 5,
    parameter int ZERO_REG = 31,
    localparam int LANES   = DATA_W / 8,
    localparam int OFF_W   = $clog2(LANES),
    localparam int SH_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              lit_sel,
    input  logic [LIT_W-1:0]  lit,
    input  logic [FN_W-1:0]   func,
    input  logic [REG_W-1:0]  dest,
    output logic [DATA_W-1:0] res,
    output logic              wr_en,
    output logic              illegal
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        logic              ill;
    } out_t;

    out_t out_d, out_q;

    logic [DATA_W-1:0] b_eff;
    kind_e             kind;
    wcode_t            wcode;
    logic              legal;
    logic [LANES-1:0]  keep;
    logic [SH_W-1:0]   sh_amt;
    logic              sh_left;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] zapped;

    assign b_eff = lit_sel ? DATA_W'(lit) : opb;

    bsu_decode u_dec (
        .func  (func),
        .kind  (kind),
        .wcode (wcode),
        .legal (legal)
    );

    bsu_lanemask #(.LANES(LANES)) u_mask (
        .kind  (kind),
        .wcode (wcode),
        .bsel  (b_eff[LANES-1:0]),
        .keep  (keep)
    );

    // byte-granular moves use offset*8, bit shifts use B[SH_W-1:0]
    always_comb begin
        sh_left = (kind == K_INS) || (kind == K_SLL);
        unique case (kind)
            K_EXT, K_INS: sh_amt = SH_W'(b_eff[OFF_W-1:0]) << 3;
            K_SRL, K_SLL: sh_amt = b_eff[SH_W-1:0];
            default:      sh_amt = '0;
        endcase
    end

    bsu_shifter #(.DATA_W(DATA_W)) u_shift (
        .din   (opa),
        .amt   (sh_amt),
        .left  (sh_left),
        .dout  (shifted)
    );

    bsu_zap #(.LANES(LANES)) u_zap (
        .din   (shifted),
        .keep  (keep),
        .dout  (zapped)
    );

    always_comb begin
        out_d     = out_q;
        out_d.we  = 1'b0;
        out_d.ill = 1'b0;
        if (in_valid) begin
            out_d.res = legal ? zapped : '0;
            out_d.we  = legal && (dest != REG_W'(ZERO_REG));
            out_d.ill = !legal;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign res     = out_q.res;
    assign wr_en   = out_q.we;
    assign illegal = out_q.ill;

    // ---------------- assertions ----------------
    p_we_ill_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && illegal));

    p_ill_zero_res_r9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (res == '0));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!wr_en && !illegal));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res));

    p_dest_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dest == REG_W'(ZERO_REG)) |=> !wr_en);

    p_zap_all_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func == FN_ZAP && b_eff[LANES-1:0] == '1) |=> (res == '0));

    p_mskq_off0_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func == FN_MSKQ && b_eff[OFF_W-1:0] == '0) |=> (res == '0));

    p_extb_narrow_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func == FN_EXTB) |=> (res[DATA_W-1:8] == '0));

    p_srl_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func == FN_SRL && b_eff[SH_W-1:0] == '0) |=> (res == $past(opa)));

endmodule

// File: tb/sim_bytezap_unit.sv
`timescale 1ns/100ps
module sim_bytezap_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        lit_sel = 1'b0;
    logic [7:0]  lit = '0;
    logic [6:0]  func = '0;
    logic [4:0]  dest = '0;
    logic [63:0] res;
    logic        wr_en;
    logic        illegal;

    always #2.5 clk = ~clk;

    bytezap_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
        .lit_sel(lit_sel), .lit(lit), .func(func), .dest(dest),
        .res(res), .wr_en(wr_en), .illegal(illegal)
    );

    typedef struct {
        logic [63:0] res;
        logic        we;
        logic        ill;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          checks = 0;
    int          errors = 0;
    logic [63:0] last_res = '0;
    bit          done = 0;

    function automatic string tag_of(input logic [6:0] f);
        case (f)
            7'h30, 7'h31:                 return "R2";
            7'h02, 7'h12, 7'h22, 7'h32:   return "R3";
            7'h06, 7'h16, 7'h26, 7'h36:   return "R4";
            7'h0B:                        return "R5";
            7'h34, 7'h39:                 return "R6";
            default:                      return "R9";
        endcase
    endfunction

    // reference model written from the requirement text
    function automatic item_t model(input logic [63:0] a, input logic [63:0] b,
                                    input logic [6:0] f, input logic [4:0] d);
        item_t  it;
        int     off = int'(b[2:0]);
        int     n;
        logic [63:0] t;
        it.res = '0; it.we = 1'b0; it.ill = 1'b0; it.tag = tag_of(f);
        case (f)
            7'h30, 7'h31: begin
                for (int i = 0; i < 8; i++)
                    if (b[i] == (f == 7'h31)) it.res[8*i +: 8] = a[8*i +: 8];
            end
            7'h02, 7'h12, 7'h22, 7'h32: begin
                n = 1 << f[5:4];
                for (int i = 0; i < 8; i++)
                    if (!(i >= off && i < off + n)) it.res[8*i +: 8] = a[8*i +: 8];
            end
            7'h06, 7'h16, 7'h26, 7'h36: begin
                n = 1 << f[5:4];
                t = a >> (off * 8);
                for (int i = 0; i < 8; i++)
                    if (i < n) it.res[8*i +: 8] = t[8*i +: 8];
            end
            7'h0B: begin
                t = a << (off * 8);
                it.res[8*off +: 8] = t[8*off +: 8];
            end
            7'h34: it.res = a >> b[5:0];
            7'h39: it.res = a << b[5:0];
            default: it.ill = 1'b1;
        endcase
        it.we = !it.ill && (d != 5'd31);
        return it;
    endfunction

    task automatic send(input logic [63:0] a, input logic [63:0] b, input logic ls,
                        input logic [7:0] l, input logic [6:0] f, input logic [4:0] d,
                        input string tg);
        item_t it;
        logic [63:0] beff;
        @(negedge clk); #1;
        beff = ls ? {56'h0, l} : b;
        it = model(a, beff, f, d);
        if (tg != "") it.tag = tg;
        last_res = it.res;
        in_valid = 1'b1; opa = a; opb = b; lit_sel = ls; lit = l; func = f; dest = d;
        sb.push_back(it);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            item_t it;
            @(negedge clk); #1;
            in_valid = 1'b0;
            opa = 64'hDEAD_BEEF_0BAD_F00D; func = 7'h30; opb = '1;
            it.res = last_res; it.we = 1'b0; it.ill = 1'b0; it.tag = "R10";
            sb.push_back(it);
        end
    endtask

    // monitor: one item per cycle, compared at the falling edge after it registers
    initial begin
        item_t e;
        @(negedge clk);
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                if (res !== e.res || wr_en !== e.we || illegal !== e.ill) begin
                    errors++;
                    $display("FAIL %s res=%h we=%b ill=%b expected res=%h we=%b ill=%b",
                             e.tag, res, wr_en, illegal, e.res, e.we, e.ill);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [63:0] PAT = 64'h8877_6655_4433_2211;

    initial begin
        logic [6:0] codes [4];
        repeat (3) @(negedge clk);
        // R1: reset state while held
        checks++;
        if (res !== '0 || wr_en !== 1'b0 || illegal !== 1'b0) begin
            errors++;
            $display("FAIL R1 res=%h we=%b ill=%b expected res=0 we=0 ill=0", res, wr_en, illegal);
        end
        #1 rst = 1'b0;
        idle(1);

        // R2: zap / zapnot with lane patterns
        send(PAT, 64'h0000_0000_0000_00A5, 0, 0, 7'h30, 5'd3, "R2");
        send(PAT, 64'h0000_0000_0000_00A5, 0, 0, 7'h31, 5'd3, "R2");
        send(PAT, '0, 1, 8'hFF, 7'h30, 5'd4, "R2");
        send(PAT, '0, 1, 8'h81, 7'h31, 5'd4, "R2");

        // R3, R4: every width at every offset
        codes = '{7'h02, 7'h12, 7'h22, 7'h32};
        foreach (codes[c])
            for (int o = 0; o < 8; o++)
                send(PAT, 64'(o), 0, 0, codes[c], 5'd1, "R3");
        codes = '{7'h06, 7'h16, 7'h26, 7'h36};
        foreach (codes[c])
            for (int o = 0; o < 8; o++)
                send(PAT, 64'hFF00_0000_0000_0000 | 64'(o), 0, 0, codes[c], 5'd2, "R4");
        idle(2);

        // R5: insert at each offset
        for (int o = 0; o < 8; o++)
            send(PAT, 64'(o), 0, 0, 7'h0B, 5'd5, "R5");

        // R6: shifts, upper B bits set must not matter
        send(64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFC1, 0, 0, 7'h34, 5'd6, "R6");
        send(64'h8000_0000_0000_0001, 64'h0000_0000_0000_0140, 0, 0, 7'h39, 5'd6, "R6");
        send(PAT, 64'd63, 0, 0, 7'h39, 5'd6, "R6");
        send(PAT, 64'd0, 0, 0, 7'h34, 5'd6, "R6");

        // R7: literal overrides the register operand
        send(PAT, 64'h0000_0000_0000_0003, 1, 8'h05, 7'h06, 5'd7, "R7");
        send(PAT, 64'hFFFF_FFFF_FFFF_FFFF, 1, 8'h04, 7'h34, 5'd7, "R7");

        // R8: destination 31
        send(PAT, 64'd2, 0, 0, 7'h16, 5'd31, "R8");
        send(PAT, 64'h0F, 0, 0, 7'h31, 5'd31, "R8");

        // R9: unassigned codes, then a legal op after
        send(PAT, 64'd1, 0, 0, 7'h00, 5'd1, "R9");
        send(PAT, 64'd1, 0, 0, 7'h7F, 5'd1, "R9");
        send(PAT, 64'd1, 0, 0, 7'h0C, 5'd31, "R9");
        send(PAT, 64'd1, 0, 0, 7'h06, 5'd1, "R9");

        // R10: hold across idle cycles
        idle(3);

        // mixed random traffic
        for (int k = 0; k < 200; k++) begin
            logic [6:0] f;
            case ($urandom_range(0, 12))
                0: f = 7'h30; 1: f = 7'h31; 2: f = 7'h02; 3: f = 7'h12;
                4: f = 7'h22; 5: f = 7'h32; 6: f = 7'h06; 7: f = 7'h16;
                8: f = 7'h26; 9: f = 7'h36; 10: f = 7'h0B; 11: f = 7'h34;
                default: f = 7'h39;
            endcase
            send({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom),
                 8'($urandom), f, 5'($urandom), "");
            if (k % 17 == 0) idle(1);
        end
        idle(2);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule